// File: doc/BRIEF.md
# Vector Table Lookup Permute

This block rearranges a vector by table lookup. Every element position of the result takes the element of a data vector that the matching element of an index vector points at. The element size is chosen per operation by a two-bit code, so one instance serves byte, halfword, word and doubleword shuffles. An index that points past the last element yields a zero element rather than wrapping around.

Inputs are sampled on the clock edge where `in_valid` is high, and the result appears one cycle later with `out_valid`. The whole data vector is captured before any part of the result is written. The result register can therefore be wired straight back to `data_vec` (the destination is the same as the table) and the lookup still reads the table as it stood before the operation.

Top module: `vtl_permute`

## Requirements
- R1: The size code `elem_size` selects the element width: 0 selects 8 bits, 1 selects 16 bits, 2 selects 32 bits and 3 selects 64 bits. Element k occupies bits [k*W +: W] of each vector.
- R2: For each position i, when the unsigned index element j is less than VBITS/W, the output element i equals data element j.
- R3: For each position i, when j is greater than or equal to VBITS/W, the output element i is zero.
- R4: The index is compared as an unsigned number at the full element width. A 64-bit index with any high bit set gives a zero element and is never reduced to its low bits.
- R5: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and the result belongs to the inputs sampled in that earlier cycle.
- R6: While `in_valid` is low, `out_vec` keeps its previous value.
- R7: When `out_vec` is fed back as `data_vec`, the new result is computed entirely from the vector as it was before the operation.
- R8: Synchronous reset clears `out_vec` to zero and `out_valid` to 0.
- R9: Positions are independent. Several positions may name the same source element and each of them receives a copy of it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Inputs are sampled this cycle |
| elem_size | input | 2 | Element width code |
| data_vec | input | VBITS | Table vector the elements are picked from |
| index_vec | input | VBITS | Selector for each element position |
| out_valid | output | 1 | Result register holds a new result |
| out_vec | output | VBITS | Permuted vector |

## Verification
The result register is the only state, so any fault in the lane selection, the range compare or the size mux shows up at `out_vec` in the cycle after the offending input. A reference model run alongside the design flags it on that same clock. A wrong enable or a wrong valid pipeline shows as an `out_valid` or `out_vec` mismatch one cycle after an idle or active input cycle. A truncated index compare is exposed only by large doubleword indices, and a broken feedback path only by runs where the output drives the table input, so both patterns are driven explicitly.

// File: rtl/vtl_pkg.sv
package vtl_pkg;

    typedef enum logic [1:0] {
        ESZ_BYTE  = 2'd0,
        ESZ_HALF  = 2'd1,
        ESZ_WORD  = 2'd2,
        ESZ_DWORD = 2'd3
    } esz_e;

    localparam int unsigned NUM_SIZES = 4;
    localparam int unsigned MIN_EW    = 8;
    localparam int unsigned MAX_EW    = 64;

    // element width in bits for a size slot
    function automatic int unsigned elem_bits(input int unsigned sz);
        return MIN_EW << sz;
    endfunction

    // element count of a vector of vbits for a size slot
    function automatic int unsigned elem_count(input int unsigned vbits, input int unsigned sz);
        return vbits / elem_bits(sz);
    endfunction

    // bits needed to address elem_count elements (never below one)
    function automatic int unsigned sel_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/vtl_size_lanes.sv
module vtl_size_lanes
    import vtl_pkg::*;
#(
    parameter int unsigned VBITS = 128,
    parameter int unsigned SZ    = 0
) (
    input  logic [VBITS-1:0] data_vec,
    input  logic [VBITS-1:0] index_vec,
    output logic [VBITS-1:0] result
);
    localparam int unsigned EW = elem_bits(SZ);
    localparam int unsigned NE = elem_count(VBITS, SZ);
    localparam int unsigned IW = sel_bits(NE);

    logic [EW-1:0] table_el [NE];

    for (genvar k = 0; k < NE; k++) begin : g_split
        assign table_el[k] = data_vec[k*EW +: EW];
    end

    for (genvar i = 0; i < NE; i++) begin : g_lane
        logic [EW-1:0] sel_raw;
        logic [63:0]   sel_wide;
        logic          in_range;
        logic [IW-1:0] sel;

        assign sel_raw  = index_vec[i*EW +: EW];
        assign sel_wide = 64'(sel_raw);
        assign in_range = sel_wide < 64'(NE);
        assign sel      = sel_raw[IW-1:0];
        assign result[i*EW +: EW] = in_range ? table_el[sel] : '0;
    end

endmodule

// File: rtl/vtl_size_mux.sv
module vtl_size_mux
    import vtl_pkg::*;
#(
    parameter int unsigned VBITS = 128
) (
    input  esz_e             esz,
    input  logic [VBITS-1:0] by_size [NUM_SIZES],
    output logic [VBITS-1:0] picked
);
    always_comb begin
        unique case (esz)
            ESZ_BYTE:  picked = by_size[0];
            ESZ_HALF:  picked = by_size[1];
            ESZ_WORD:  picked = by_size[2];
            default:   picked = by_size[3];
        endcase
    end
endmodule

// File: rtl/vtl_permute.sv
module vtl_permute
    import vtl_pkg::*;
#(
    parameter int unsigned VBITS = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       elem_size,
    input  logic [VBITS-1:0] data_vec,
    input  logic [VBITS-1:0] index_vec,
    output logic             out_valid,
    output logic [VBITS-1:0] out_vec
);
    localparam int unsigned NE_BYTE = elem_count(VBITS, 0);

    esz_e             esz;
    logic [VBITS-1:0] size_res [NUM_SIZES];
    logic [VBITS-1:0] next_vec;

    assign esz = esz_e'(elem_size);

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        vtl_size_lanes #(.VBITS(VBITS), .SZ(s)) u_lanes (
            .data_vec  (data_vec),
            .index_vec (index_vec),
            .result    (size_res[s])
        );
    end

    vtl_size_mux #(.VBITS(VBITS)) u_mux (
        .esz     (esz),
        .by_size (size_res),
        .picked  (next_vec)
    );

    // whole result written in one edge from inputs sampled at that edge
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_vec   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_vec <= next_vec;
            end
        end
    end

    a_r5_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r5_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_vec));
    a_r3_byte0_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && elem_size == 2'd0 && 32'(index_vec[7:0]) >= NE_BYTE)
        |=> out_vec[7:0] == 8'h00);
    a_r2_byte0_pick: assert property (@(posedge clk) disable iff (rst)
        (in_valid && elem_size == 2'd0 && 32'(index_vec[7:0]) < NE_BYTE)
        |=> out_vec[7:0] == 8'($past(data_vec >> {index_vec[7:0], 3'b000})));
    a_r4_dword0_wide_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && elem_size == 2'd3 && index_vec[63:32] != 32'd0)
        |=> out_vec[63:0] == 64'd0);

endmodule

// File: tb/sim_vtl_permute.sv
module sim_vtl_permute;
    localparam int VB = 128;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [1:0]    elem_size = 2'd0;
    logic [VB-1:0] data_vec = '0;
    logic [VB-1:0] index_vec = '0;
    logic          out_valid;
    logic [VB-1:0] out_vec;

    int    n_checks = 0;
    int    n_fails  = 0;
    int    cyc      = 0;
    bit    done     = 1'b0;
    string cur_req  = "R8";

    logic          m_valid = 1'b0;
    logic [VB-1:0] m_vec   = '0;

    always #5 clk = ~clk;

    vtl_permute #(.VBITS(VB)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .elem_size(elem_size),
        .data_vec(data_vec), .index_vec(index_vec),
        .out_valid(out_valid), .out_vec(out_vec)
    );

    function automatic logic [VB-1:0] ref_tbl(input logic [VB-1:0] d,
                                              input logic [VB-1:0] ix,
                                              input logic [1:0] sz);
        logic [VB-1:0] r = '0;
        int ew = 8 << sz;
        int ne = VB / ew;
        for (int i = 0; i < ne; i++) begin
            logic [63:0] j = '0;
            for (int b = 0; b < ew; b++) j[b] = ix[i*ew + b];
            if (j < 64'(ne)) begin
                for (int b = 0; b < ew; b++) r[i*ew + b] = d[int'(j)*ew + b];
            end
        end
        return r;
    endfunction

    // behavioural reference: one result slot, updated on accepted inputs
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m_valid <= 1'b0;
            m_vec   <= '0;
        end else begin
            m_valid <= in_valid;
            if (in_valid) m_vec <= ref_tbl(data_vec, index_vec, elem_size);
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_checks++;
            if (out_valid !== m_valid || out_vec !== m_vec) begin
                n_fails++;
                $display("FAIL %s: out_valid=%0b out_vec=%h expected out_valid=%0b out_vec=%h",
                         cur_req, out_valid, out_vec, m_valid, m_vec);
            end
        end
    end

    function automatic logic [VB-1:0] rnd_vec();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    // mode 0: in range, 1: just past the end, 2: mixed, 3: all lanes pick one element
    function automatic logic [VB-1:0] make_idx(input logic [1:0] sz, input int mode);
        logic [VB-1:0] r = '0;
        int ew = 8 << sz;
        int ne = VB / ew;
        int same = int'($urandom() % ne);
        for (int i = 0; i < ne; i++) begin
            logic [63:0] v;
            case (mode)
                0: v = 64'($urandom() % ne);
                1: v = 64'(ne + ($urandom() % 4));
                2: v = ($urandom() % 2 == 0) ? 64'($urandom() % ne) : 64'(ne + i);
                default: v = 64'(same);
            endcase
            for (int b = 0; b < ew; b++) r[i*ew + b] = v[b];
        end
        return r;
    endfunction

    task automatic drive(input logic v, input logic [1:0] sz,
                         input logic [VB-1:0] d, input logic [VB-1:0] ix);
        @(negedge clk);
        in_valid  = v;
        elem_size = sz;
        data_vec  = d;
        index_vec = ix;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        for (int s = 0; s < 4; s++) begin
            cur_req = "R1 R2";
            for (int k = 0; k < 6; k++) drive(1'b1, 2'(s), rnd_vec(), make_idx(2'(s), 0));
            cur_req = "R3";
            for (int k = 0; k < 4; k++) drive(1'b1, 2'(s), rnd_vec(), make_idx(2'(s), 1));
            cur_req = "R2 R3";
            for (int k = 0; k < 4; k++) drive(1'b1, 2'(s), rnd_vec(), make_idx(2'(s), 2));
            cur_req = "R9";
            for (int k = 0; k < 3; k++) drive(1'b1, 2'(s), rnd_vec(), make_idx(2'(s), 3));
        end

        cur_req = "R4";
        drive(1'b1, 2'd3, rnd_vec(), {64'h0000_0001_0000_0000, 64'h8000_0000_0000_0001});
        drive(1'b1, 2'd3, rnd_vec(), {64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF});
        drive(1'b1, 2'd2, rnd_vec(), {32'h0000_0000, 32'h8000_0001, 32'h0000_0003, 32'hFFFF_FFFF});

        cur_req = "R5 R6";
        for (int k = 0; k < 12; k++) begin
            logic [1:0] sz = 2'($urandom() % 4);
            drive(1'($urandom() % 2), sz, rnd_vec(), make_idx(sz, 2));
        end
        drive(1'b0, 2'd1, rnd_vec(), make_idx(2'd1, 0));
        drive(1'b0, 2'd0, rnd_vec(), make_idx(2'd0, 0));

        cur_req = "R7";
        drive(1'b1, 2'd0, rnd_vec(), make_idx(2'd0, 0));
        for (int k = 0; k < 8; k++) begin
            logic [1:0] sz = 2'(k % 4);
            @(negedge clk);
            in_valid  = 1'b1;
            elem_size = sz;
            data_vec  = out_vec;
            index_vec = make_idx(sz, (k == 5) ? 2 : 0);
        end

        cur_req = "R8";
        drive(1'b1, 2'd0, rnd_vec(), make_idx(2'd0, 0));
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_fails++;
            $display("FAIL watchdog: run did not complete, cycles=%0d expected below 20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule